// File: doc/BRIEF.md
# Unit Buffer Partition Allocator

This block splits one shared on-chip entry buffer into five back-to-back regions. The regions belong to the vertex, geometry, clip, setup and constant units. A recompute strobe hands it the buffer size, three requested entry sizes and a device-variant code. It then searches for per-unit entry counts that fit. It starts with generous counts and falls back to smaller ones. It returns the start offset of every region.

A sticky constrained mode records that the last layout had to settle for reduced counts. While this mode is set, a later request with smaller entry sizes also triggers a new search, so the layout can grow back. Outside constrained mode, only growth of an entry size triggers a search. The fit is evaluated one region per cycle with a single multiplier. A busy/done handshake frames each accepted strobe. An update pulse marks every strobe that produced a new layout.

Top module: `unit_buf_alloc`

## Requirements
- R1: The regions follow the fixed order vertex, geometry, clip, setup, constant, and the vertex start is always 0. Each later start equals the previous start plus the previous count times the previous region's entry size. The vertex, geometry and clip regions use the vertex entry size, the setup region uses the setup size, and the constant region uses the constant size.
- R2: A layout fits when the constant start plus the constant count times the constant size is no larger than the total size.
- R3: A requested entry size of 0 is treated as 1 before any comparison or use.
- R4: A search runs only when a clamped requested size is larger than the stored size for that region kind, or when constrained mode is set and a clamped requested size is smaller. Otherwise done pulses with no update, and the offsets and flags keep their values.
- R5: A search stores the clamped sizes and clears constrained mode. Its normal counts are vertex 32, clip 10, geometry 8, setup 8 and constant 4.
- R6: With variant code 2 the first trial uses vertex 128 and setup 48, and with code 1 it uses vertex 64. The other counts in that trial are normal. Codes 0 and 3 skip this trial. A failed first trial sets constrained mode and falls back to the normal counts.
- R7: If the normal counts do not fit, the search uses the minimum counts and sets constrained mode. The minimum counts are vertex 16, clip 5, geometry 4, setup 1 and constant 1.
- R8: If the minimum counts do not fit, the error flag is set and the minimum-count offsets are reported (modulo 2^10). The error flag is cleared by the next search.
- R9: Every completed search raises update for exactly one cycle, in the same cycle as done.
- R10: A strobe while idle is accepted, and busy stays high while a search runs. Done pulses for one cycle once per accepted strobe, and busy is low in that cycle. A strobe while busy is ignored, and so are input changes during that time.
- R11: After reset all offsets are 0, and busy, done, update, constrained and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| recompute_i | input | 1 | Strobe requesting a layout check |
| variant_i | input | 2 | Device-variant code selecting the first trial |
| total_i | input | OFF_W | Total buffer size in entry units (256 or 384 in use) |
| vtx_size_i | input | SZ_W | Requested vertex entry size |
| set_size_i | input | SZ_W | Requested setup entry size |
| con_size_i | input | SZ_W | Requested constant entry size |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle pulse ending an accepted strobe |
| update_o | output | 1 | One-cycle pulse: a new layout was computed |
| constrained_o | output | 1 | Layout uses reduced counts |
| error_o | output | 1 | Even the minimum counts did not fit |
| vtx_start_o | output | OFF_W | Vertex region start |
| geo_start_o | output | OFF_W | Geometry region start |
| clp_start_o | output | OFF_W | Clip region start |
| set_start_o | output | OFF_W | Setup region start |
| con_start_o | output | OFF_W | Constant region start |

## Verification
The bench sends a series of strobes that reach each exit of the search. A small layout with normal counts fits at once. Large-trial layouts for variants 1 and 2 fit in some runs and fail in others. Sizes force the minimum counts in one run and overflow even those in another. Between them come repeated strobes with equal or smaller sizes. These show whether the block tells a real trigger from a no-op in and out of constrained mode. Requests of size 0 test the clamp. Variant 3 must behave like variant 0. One strobe arrives mid-search together with changed inputs, which shows whether the running search latched its inputs and ignored the second request.

// File: rtl/uab_pkg.sv
package uab_pkg;
  localparam int NREG  = 5;
  localparam int CNT_W = 8;
  localparam int IDX_W = $clog2(NREG);

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_CHECK} state_e;
  typedef enum logic [1:0] {TR_WIDE, TR_PREF, TR_MIN}   trial_e;
endpackage

// File: rtl/uab_count_table.sv
module uab_count_table
  import uab_pkg::*;
(
  input  trial_e           trial_i,
  input  logic [1:0]       variant_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] pref_cnt;
  logic [CNT_W-1:0] min_cnt;

  always_comb begin
    case (idx_i)
      3'd0:    begin pref_cnt = 8'd32; min_cnt = 8'd16; end
      3'd1:    begin pref_cnt = 8'd8;  min_cnt = 8'd4;  end
      3'd2:    begin pref_cnt = 8'd10; min_cnt = 8'd5;  end
      3'd3:    begin pref_cnt = 8'd8;  min_cnt = 8'd1;  end
      default: begin pref_cnt = 8'd4;  min_cnt = 8'd1;  end
    endcase
  end

  always_comb begin
    count_o = pref_cnt;
    if (trial_i == TR_MIN) begin
      count_o = min_cnt;
    end else if (trial_i == TR_WIDE) begin
      if (variant_i == 2'd2 && idx_i == 3'd0) count_o = 8'd128;
      if (variant_i == 2'd2 && idx_i == 3'd3) count_o = 8'd48;
      if (variant_i == 2'd1 && idx_i == 3'd0) count_o = 8'd64;
    end
  end
endmodule

// File: rtl/uab_layout_eval.sv
module uab_layout_eval
  import uab_pkg::*;
#(
  parameter int SZ_W  = 6,
  parameter int ACC_W = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       step_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [CNT_W-1:0]           count_i,
  input  logic [SZ_W-1:0]            size_i,
  output logic [ACC_W-1:0]           acc_o,
  output logic [NREG-1:0][ACC_W-1:0] starts_o
);
  logic [ACC_W-1:0]           acc_q, acc_d;
  logic [NREG-1:0][ACC_W-1:0] st_q, st_d;
  logic [ACC_W-1:0]           prod;

  assign prod = ACC_W'(count_i) * ACC_W'(size_i);

  always_comb begin
    acc_d = acc_q;
    st_d  = st_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (step_i) begin
      acc_d = acc_q + prod;
    end
    for (int i = 0; i < NREG; i++) begin
      if (step_i && !clr_i && idx_i == IDX_W'(i)) st_d[i] = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      st_q  <= '0;
    end else begin
      acc_q <= acc_d;
      st_q  <= st_d;
    end
  end

  assign acc_o    = acc_q;
  assign starts_o = st_q;

  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (idx_i < IDX_W'(NREG)));
  p_acc_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/unit_buf_alloc.sv
module unit_buf_alloc
  import uab_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int SZ_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recompute_i,
  input  logic [1:0]       variant_i,
  input  logic [OFF_W-1:0] total_i,
  input  logic [SZ_W-1:0]  vtx_size_i,
  input  logic [SZ_W-1:0]  set_size_i,
  input  logic [SZ_W-1:0]  con_size_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             update_o,
  output logic             constrained_o,
  output logic             error_o,
  output logic [OFF_W-1:0] vtx_start_o,
  output logic [OFF_W-1:0] geo_start_o,
  output logic [OFF_W-1:0] clp_start_o,
  output logic [OFF_W-1:0] set_start_o,
  output logic [OFF_W-1:0] con_start_o
);
  localparam int ACC_W = CNT_W + SZ_W + 3;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  state_e                     state_q, state_d;
  trial_e                     trial_q, trial_d;
  logic [IDX_W-1:0]           idx_q, idx_d;
  logic [SZ_W-1:0]            vsz_q, vsz_d, ssz_q, ssz_d, csz_q, csz_d;
  logic                       cons_q, cons_d, err_q, err_d;
  logic                       done_q, done_d, upd_q, upd_d;
  logic [OFF_W-1:0]           total_q, total_d;
  logic [1:0]                 var_q, var_d;
  logic [NREG-1:0][OFF_W-1:0] out_q, out_d;

  logic [SZ_W-1:0]            vreq, sreq, creq, cur_size;
  logic                       need_rc, grow, shrink, fit, clr, step;
  logic [CNT_W-1:0]           cur_count;
  logic [ACC_W-1:0]           acc;
  logic [NREG-1:0][ACC_W-1:0] starts;

  assign vreq = (vtx_size_i == '0) ? SZ_W'(1) : vtx_size_i;
  assign sreq = (set_size_i == '0) ? SZ_W'(1) : set_size_i;
  assign creq = (con_size_i == '0) ? SZ_W'(1) : con_size_i;

  assign grow    = (vreq > vsz_q) || (sreq > ssz_q) || (creq > csz_q);
  assign shrink  = (vreq < vsz_q) || (sreq < ssz_q) || (creq < csz_q);
  assign need_rc = grow || (cons_q && shrink);

  assign cur_size = (idx_q == 3'd3) ? ssz_q :
                    (idx_q == 3'd4) ? csz_q : vsz_q;
  assign step = (state_q == ST_EVAL);
  assign fit  = (acc <= ACC_W'(total_q));

  uab_count_table u_cnt (
    .trial_i   (trial_q),
    .variant_i (var_q),
    .idx_i     (idx_q),
    .count_o   (cur_count)
  );

  uab_layout_eval #(.SZ_W(SZ_W), .ACC_W(ACC_W)) u_eval (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (clr),
    .step_i   (step),
    .idx_i    (idx_q),
    .count_i  (cur_count),
    .size_i   (cur_size),
    .acc_o    (acc),
    .starts_o (starts)
  );

  always_comb begin
    state_d = state_q;  trial_d = trial_q;  idx_d = idx_q;
    vsz_d   = vsz_q;    ssz_d   = ssz_q;    csz_d = csz_q;
    cons_d  = cons_q;   err_d   = err_q;
    total_d = total_q;  var_d   = var_q;    out_d = out_q;
    done_d  = 1'b0;     upd_d   = 1'b0;     clr   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (recompute_i) begin
          if (need_rc) begin
            vsz_d   = vreq;  ssz_d = sreq;  csz_d = creq;
            cons_d  = 1'b0;  err_d = 1'b0;
            total_d = total_i;
            var_d   = variant_i;
            trial_d = (variant_i == 2'd1 || variant_i == 2'd2) ? TR_WIDE : TR_PREF;
            idx_d   = '0;
            clr     = 1'b1;
            state_d = ST_EVAL;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_EVAL: begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == LAST) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (fit || trial_q == TR_MIN) begin
          for (int i = 0; i < NREG; i++) out_d[i] = starts[i][OFF_W-1:0];
          err_d   = !fit;
          done_d  = 1'b1;
          upd_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cons_d  = 1'b1;
          trial_d = (trial_q == TR_WIDE) ? TR_PREF : TR_MIN;
          idx_d   = '0;
          clr     = 1'b1;
          state_d = ST_EVAL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;  trial_q <= TR_PREF;  idx_q <= '0;
      vsz_q   <= '0;       ssz_q   <= '0;       csz_q <= '0;
      cons_q  <= 1'b0;     err_q   <= 1'b0;
      done_q  <= 1'b0;     upd_q   <= 1'b0;
      total_q <= '0;       var_q   <= '0;       out_q <= '0;
    end else begin
      state_q <= state_d;  trial_q <= trial_d;  idx_q <= idx_d;
      vsz_q   <= vsz_d;    ssz_q   <= ssz_d;    csz_q <= csz_d;
      cons_q  <= cons_d;   err_q   <= err_d;
      done_q  <= done_d;   upd_q   <= upd_d;
      total_q <= total_d;  var_q   <= var_d;    out_q <= out_d;
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign update_o      = upd_q;
  assign constrained_o = cons_q;
  assign error_o       = err_q;
  assign vtx_start_o   = out_q[0];
  assign geo_start_o   = out_q[1];
  assign clp_start_o   = out_q[2];
  assign set_start_o   = out_q[3];
  assign con_start_o   = out_q[4];

  p_update_with_done_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_q |-> done_q);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |=> !done_q);
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |-> !busy_o);
  p_vtx_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (vtx_start_o == '0));
  p_order_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!err_q && !busy_o) |-> (geo_start_o >= vtx_start_o && clp_start_o >= geo_start_o &&
                             set_start_o >= clp_start_o && con_start_o >= set_start_o));
  p_fit_bound_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (upd_q && !err_q) |-> (con_start_o <= total_q));
  p_err_constrained_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_q |-> cons_q);
  p_noop_stable_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_q && !upd_q) |-> ($stable(con_start_o) && $stable(cons_q) && $stable(err_q)));
endmodule

// File: tb/unit_buf_alloc_tb.sv
`timescale 1ns/1ps
module unit_buf_alloc_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       recompute;
  logic [1:0] variant;
  logic [9:0] total;
  logic [5:0] vsz, ssz, csz;
  logic       busy, done, update, cons, err;
  logic [9:0] s0, s1, s2, s3, s4;

  always #4 clk = ~clk;

  unit_buf_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .recompute_i(recompute), .variant_i(variant),
    .total_i(total), .vtx_size_i(vsz), .set_size_i(ssz), .con_size_i(csz),
    .busy_o(busy), .done_o(done), .update_o(update), .constrained_o(cons),
    .error_o(err), .vtx_start_o(s0), .geo_start_o(s1), .clp_start_o(s2),
    .set_start_o(s3), .con_start_o(s4)
  );

  typedef struct {
    int upd; int cons; int err;
    int a0; int a1; int a2; int a3; int a4;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  int mv = 0, ms = 0, mc = 0, mcons = 0, merr = 0;
  int mo[5] = '{0, 0, 0, 0, 0};
  int wst[5];

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic layout(input int c0, input int c1, input int c2, input int c3,
                        input int c4, output int endv);
    wst[0] = 0;
    wst[1] = wst[0] + c0 * mv;
    wst[2] = wst[1] + c1 * mv;
    wst[3] = wst[2] + c2 * mv;
    wst[4] = wst[3] + c3 * ms;
    endv   = wst[4] + c4 * mc;
  endtask

  // Reference model built from R1-style rules; pushes one expected item.
  task automatic predict(input int var_c, input int tot, input int v, input int s, input int c);
    exp_t e;
    int need, endv, ok;
    v = (v == 0) ? 1 : v;  s = (s == 0) ? 1 : s;  c = (c == 0) ? 1 : c;   // R3
    need = (v > mv || s > ms || c > mc || (mcons != 0 && (v < mv || s < ms || c < mc)));
    if (need != 0) begin
      mv = v; ms = s; mc = c; mcons = 0; merr = 0; ok = 0;
      if (var_c == 2 || var_c == 1) begin
        if (var_c == 2) layout(128, 8, 10, 48, 4, endv);
        else            layout(64, 8, 10, 8, 4, endv);
        if (endv <= tot) ok = 1; else mcons = 1;
      end
      if (ok == 0) begin
        layout(32, 8, 10, 8, 4, endv);
        if (endv <= tot) ok = 1;
      end
      if (ok == 0) begin
        mcons = 1;
        layout(16, 4, 5, 1, 1, endv);
        if (endv > tot) merr = 1;
      end
      for (int i = 0; i < 5; i++) mo[i] = wst[i] % 1024;
    end
    e.upd = need; e.cons = mcons; e.err = merr;
    e.a0 = mo[0]; e.a1 = mo[1]; e.a2 = mo[2]; e.a3 = mo[3]; e.a4 = mo[4];
    exp_q.push_back(e);
  endtask

  task automatic run(input int var_c, input int tot, input int v, input int s,
                     input int c, input int poke);
    @(negedge clk);
    while (busy) @(negedge clk);
    predict(var_c, tot, v, s, c);
    variant = 2'(var_c); total = 10'(tot);
    vsz = 6'(v); ssz = 6'(s); csz = 6'(c);
    recompute = 1'b1;
    @(negedge clk);
    recompute = 1'b0;
    if (poke != 0) begin
      // R10: second strobe and changed inputs during a search are ignored
      @(negedge clk);
      vsz = 6'd60; total = 10'd8; variant = 2'd0;
      recompute = 1'b1;
      @(negedge clk);
      recompute = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected done: actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R9/R4", "update", int'(update), e.upd);
        chk("R10", "busy at done", int'(busy), 0);
        chk("R1", "vertex start", int'(s0), e.a0);
        chk("R1", "geometry start", int'(s1), e.a1);
        chk("R1", "clip start", int'(s2), e.a2);
        chk("R5", "setup start", int'(s3), e.a3);
        chk("R2", "constant start", int'(s4), e.a4);
        chk("R6/R7", "constrained", int'(cons), e.cons);
        chk("R8", "error", int'(err), e.err);
      end
    end
  end

  task automatic main_seq();
    rst_n = 1'b0; recompute = 1'b0; variant = 2'd0; total = 10'd256;
    vsz = 6'd0; ssz = 6'd0; csz = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "done", int'(done), 0);
    chk("R11", "update", int'(update), 0);
    chk("R11", "constrained", int'(cons), 0);
    chk("R11", "error", int'(err), 0);
    chk("R11", "constant start", int'(s4), 0);
    chk("R11", "setup start", int'(s3), 0);

    run(0, 256, 0, 2, 4, 0);   // R3 clamp on vertex, R5 normal counts fit
    run(0, 256, 1, 2, 4, 0);   // R4 equal sizes: no-op
    run(0, 256, 1, 1, 1, 0);   // R4 smaller, not constrained: no-op
    run(2, 256, 3, 2, 4, 1);   // R6 wide trial fails, constrained; R10 poke
    run(2, 256, 2, 2, 4, 0);   // R4 constrained shrink: recompute
    run(1, 384, 3, 2, 4, 0);   // R6 variant 1 wide trial fits
    run(2, 384, 1, 1, 1, 0);   // R4 no-op (not constrained, smaller)
    run(0, 256, 5, 12, 32, 0); // R7 minimum counts
    run(0, 256, 20, 12, 32, 0);// R8 even minimum fails
    run(3, 256, 0, 0, 0, 0);   // R3/R8 error cleared, variant 3 like 0
    run(2, 384, 2, 1, 1, 0);   // R6 variant 2 wide fits at 384
    run(1, 256, 5, 12, 32, 1); // R6 wide fails then R7 minimum; R10 poke
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog expired: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule